// File: doc/BRIEF.md
# Receive FIFO Idle Watchdog

This block watches a receive FIFO that holds characters but has seen no recent activity. It counts bit-time ticks from the baud generator and restarts the count on every FIFO event. A FIFO event is a push of a received character, or a read through any of the FIFO's read ports. When the idle count passes a fixed limit, the block raises a timeout flag.

The interrupt logic takes this flag as a separate interrupt source. It lets the host collect a few trailing characters that never reach the FIFO fill-level interrupt threshold. The flag clears itself on the next FIFO event, so the host needs no acknowledge. It reads the FIFO and the flag drops.

The counter advances only while the watchdog is enabled and the FIFO holds data. It saturates after the timeout, so the flag rises once per idle period. The baud generator and the FIFO storage are outside this block.

Top module: `rxq_idle_watchdog`

## Requirements
- R1: After reset, `wd_timeout` is 0 and the idle count is 0.
- R2: `wd_timeout` becomes 1 after the clock edge that samples the 65th counted `bit_tick` (LIMIT+1, LIMIT = 64) since the last FIFO event. After the 64th counted tick it is still 0.
- R3: A cycle with `rx_push` high clears `wd_timeout` at the next edge and restarts the idle count from zero.
- R4: A cycle with any bit of `rx_read` high clears `wd_timeout` at the next edge and restarts the idle count from zero. Bit 0 is the local read port and bit 1 is the global read port.
- R5: `bit_tick` is ignored while `wd_en` is 0 or `rx_not_empty` is 0. The partial count is kept and resumes when both are 1 again.
- R6: Once set, `wd_timeout` stays 1 for any number of further ticks until a FIFO event. It rises only once per idle period.
- R7: A FIFO event in the same cycle as a counted tick wins. The count restarts from zero and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wd_en | input | 1 | Watchdog enable |
| bit_tick | input | 1 | One-cycle strobe per receive bit time |
| rx_push | input | 1 | Received character pushed into the FIFO |
| rx_read | input | N_RD | FIFO read strobes, one per read port (bit 0 local, bit 1 global) |
| rx_not_empty | input | 1 | FIFO holds at least one character |
| wd_timeout | output | 1 | Idle timeout status bit |

## Verification
Every result is registered once. A tick or event that is driven in one cycle shows on `wd_timeout` after the next rising edge. The bench drives inputs on the falling edge and samples at the following falling edge, half a cycle after the edge that updates the flag. Limit checks come in pairs: `wd_timeout` is checked low after tick 64 and high after tick 65. Suspended, event-coincident and saturated cases are checked the same way, one falling edge after their decisive tick.

// File: rtl/rxwd_pkg.sv
package rxwd_pkg;
   // Width needed to hold 0..top inclusive.
   function automatic int unsigned cnt_width(input int unsigned top);
      return (top < 2) ? 1 : $clog2(top + 1);
   endfunction
endpackage

// File: rtl/rxwd_event_merge.sv
module rxwd_event_merge #(
   parameter int unsigned N_RD = 2
) (
   input  logic            push_i,
   input  logic [N_RD-1:0] read_i,
   output logic            event_o
);
   logic [N_RD:0] chain;

   assign chain[0] = push_i;
   for (genvar g = 0; g < N_RD; g++) begin : g_rd
      assign chain[g+1] = chain[g] | read_i[g];
   end
   assign event_o = chain[N_RD];
endmodule

// File: rtl/rxwd_tick_counter.sv
module rxwd_tick_counter #(
   parameter int unsigned LIMIT = 64,
   parameter int unsigned CNT_W = rxwd_pkg::cnt_width(LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             advance_i,
   output logic             expire_o,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT + 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (restart_i)                 cnt_q <= '0;
      else if (advance_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = advance_i && !restart_i && (cnt_q == TOP - 1'b1);
   assign count_o  = cnt_q;

   p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (count_o == '0));
   p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance_i && !restart_i) |=> $stable(count_o));
   p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == TOP && !restart_i) |=> (count_o == TOP));
endmodule

// File: rtl/rxwd_flag.sv
module rxwd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic set_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_o <= 1'b0;
      else if (clear_i) flag_o <= 1'b0;
      else if (set_i)   flag_o <= 1'b1;
   end

   p_clear_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !flag_o);
   p_hold_until_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clear_i) |=> flag_o);
endmodule

// File: rtl/rxq_idle_watchdog.sv
module rxq_idle_watchdog #(
   parameter int unsigned LIMIT = 64,
   parameter int unsigned N_RD  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wd_en,
   input  logic            bit_tick,
   input  logic            rx_push,
   input  logic [N_RD-1:0] rx_read,
   input  logic            rx_not_empty,
   output logic            wd_timeout
);
   localparam int unsigned CNT_W = rxwd_pkg::cnt_width(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rxq_idle_watchdog: LIMIT must be at least 1");
   end
   if (N_RD < 1) begin : g_bad_nrd
      $error("rxq_idle_watchdog: N_RD must be at least 1");
   end

   logic             fifo_event;
   logic             advance;
   logic             expire;
   logic [CNT_W-1:0] idle_cnt;

   rxwd_event_merge #(.N_RD(N_RD)) u_merge (
      .push_i  (rx_push),
      .read_i  (rx_read),
      .event_o (fifo_event)
   );

   assign advance = bit_tick & wd_en & rx_not_empty;

   rxwd_tick_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (fifo_event),
      .advance_i (advance),
      .expire_o  (expire),
      .count_o   (idle_cnt)
   );

   rxwd_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (fifo_event),
      .set_i   (expire),
      .flag_o  (wd_timeout)
   );

   p_rise_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_timeout) |-> (idle_cnt == CNT_W'(LIMIT + 1)));
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_read) |=> (!wd_timeout && idle_cnt == '0));
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (!wd_timeout && idle_cnt == '0));
endmodule

// File: tb/test_rxq_idle_watchdog.sv
`timescale 1ns/1ps
module test_rxq_idle_watchdog;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wd_en = 1'b0;
   logic       bit_tick = 1'b0;
   logic       rx_push = 1'b0;
   logic [1:0] rx_read = 2'b00;
   logic       rx_not_empty = 1'b0;
   logic       wd_timeout;

   int n_run = 0;
   int n_fail = 0;
   int rises = 0;
   logic prev_to = 1'b0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   rxq_idle_watchdog #(.LIMIT(64), .N_RD(2)) i_rxq_idle_watchdog (
      .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .bit_tick(bit_tick),
      .rx_push(rx_push), .rx_read(rx_read), .rx_not_empty(rx_not_empty),
      .wd_timeout(wd_timeout)
   );

   always @(posedge clk) begin
      if (rst_n && wd_timeout && !prev_to) rises++;
      prev_to <= wd_timeout;
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: wd_timeout=%0b expected %0b", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; @(negedge clk);
         bit_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic pulse_event(input logic push, input logic [1:0] rd);
      rx_push = push; rx_read = rd; @(negedge clk);
      rx_push = 1'b0; rx_read = 2'b00; @(negedge clk);
   endtask

   task automatic t_reset_r1();
      rst_n = 1'b0; @(negedge clk); @(negedge clk);
      check("R1 reset", wd_timeout, 1'b0);
      rst_n = 1'b1; wd_en = 1'b1; rx_not_empty = 1'b1; @(negedge clk);
      ticks(64);
      check("R1 count zero after reset (64 ticks)", wd_timeout, 1'b0);
   endtask

   task automatic t_limit_r2();
      pulse_event(1'b1, 2'b00);
      ticks(64);
      check("R2 tick 64", wd_timeout, 1'b0);
      ticks(1);
      check("R2 tick 65", wd_timeout, 1'b1);
   endtask

   task automatic t_push_r3();
      pulse_event(1'b1, 2'b00);
      check("R3 push clears", wd_timeout, 1'b0);
      ticks(64);
      check("R3 restart tick 64", wd_timeout, 1'b0);
      ticks(1);
      check("R3 restart tick 65", wd_timeout, 1'b1);
   endtask

   task automatic t_read_r4(input logic [1:0] rd, input string nm);
      pulse_event(1'b0, rd);
      check({"R4 clear by ", nm}, wd_timeout, 1'b0);
      ticks(64);
      check({"R4 restart tick 64 ", nm}, wd_timeout, 1'b0);
      ticks(1);
      check({"R4 restart tick 65 ", nm}, wd_timeout, 1'b1);
   endtask

   task automatic t_suspend_r5();
      pulse_event(1'b1, 2'b00);
      ticks(30);
      wd_en = 1'b0; ticks(50);
      check("R5 disabled", wd_timeout, 1'b0);
      wd_en = 1'b1; rx_not_empty = 1'b0; ticks(50);
      check("R5 empty", wd_timeout, 1'b0);
      rx_not_empty = 1'b1; ticks(34);
      check("R5 resumed total 64", wd_timeout, 1'b0);
      ticks(1);
      check("R5 resumed total 65", wd_timeout, 1'b1);
   endtask

   task automatic t_saturate_r6();
      int r0;
      r0 = rises;
      ticks(200);
      check("R6 held after 200 more ticks", wd_timeout, 1'b1);
      n_run++;
      if (rises != r0) begin
         n_fail++;
         $display("FAIL R6: extra rises=%0d expected 0", rises - r0);
      end
   endtask

   task automatic t_coincide_r7();
      pulse_event(1'b1, 2'b00);
      ticks(64);
      bit_tick = 1'b1; rx_push = 1'b1; @(negedge clk);
      bit_tick = 1'b0; rx_push = 1'b0; @(negedge clk);
      check("R7 event beats tick", wd_timeout, 1'b0);
      ticks(64);
      check("R7 tick 64 after event", wd_timeout, 1'b0);
      ticks(1);
      check("R7 tick 65 after event", wd_timeout, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset_r1();
      t_limit_r2();
      t_push_r3();
      t_read_r4(2'b01, "local");
      t_read_r4(2'b10, "global");
      t_suspend_r5();
      t_saturate_r6();
      t_coincide_r7();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: run did not complete");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule